// File: doc/BRIEF.md
# Display Control Register Bank with Serial Write Port

This block holds the sixteen control and adjustment bytes of a video processing chip and fills them from a two-wire serial bus (I2C, write transfers only). A controller sends a START, the fixed device address byte 0x88, a sub-address byte, and one or more data bytes, then a STOP. The block answers every accepted byte with an acknowledge bit by pulling SDA low through an output enable. Both bus lines are sampled on a fast system clock through two-flop synchronisers, and edges, START and STOP are detected on the synchronised samples.

Two update modes are available. A buffer-enable bit sits in bit 5 of sub-address 0x0C. When that bit is 0, each data byte is written straight into its working register and the sub-address steps forward, wrapping from 0x0F to 0x00. When it is 1, one data byte per transfer is held in a staging register. That byte is copied to its working register on the next rising edge of the vertical-blanking strobe. Until the copy has happened, every further data byte is refused. An active-low power-fail reset loads every implemented register with 0x01 and returns the bus receiver to idle.

Top module: `dcr_bank_top`

## Requirements
- R1: Only the address byte 0x88 (7-bit address 1000100, write bit 0) is acknowledged. Any other address byte is not acknowledged, and the rest of that transfer is ignored.
- R2: For an acknowledged byte, sda_oe rises after the SCL falling edge that ends the eighth bit. It falls again after the next SCL falling edge.
- R3: A sub-address byte of 0x10 or above is not acknowledged, and no register changes.
- R4: Sub-addresses 0x07, 0x08, 0x09, 0x0B and 0x0F are acknowledged, but writes to them have no effect; their output bytes always read 0x00.
- R5: With the buffer-enable bit (0x0C bit 5) at 0, every data byte is acknowledged and written immediately. The sub-address then increments, and it wraps from 0x0F to 0x00.
- R6: Sub-addresses 0x00 to 0x06 and 0x0A keep only bits 5..0, and bits 7..6 read 0. Sub-addresses 0x0C, 0x0D and 0x0E keep all 8 bits. In 0x0D, bit 0 is switch-1 on, bit 1 is switch-1 disable, bit 2 is switch-2 on, bit 3 is switch-2 disable and bit 4 is cut-off control off.
- R7: With the buffer-enable bit at 1, the first data byte of a transfer is acknowledged and staged, and the outputs do not change. The target register takes the staged byte one clock after the next rising edge of vblank.
- R8: With the buffer-enable bit at 1, a second data byte in the same transfer is not acknowledged. Any data byte that arrives while a staged byte is waiting is also not acknowledged.
- R9: While pfail_n is low, every implemented register reads 0x01, the reserved bytes read 0x00 and sda_oe is 0.
- R10: After a byte that is not acknowledged, the block stays silent until the next START or STOP. A new START begins a fresh transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| pfail_n | input | 1 | Active-low power-fail reset, asynchronous |
| scl_i | input | 1 | Serial clock line as sensed |
| sda_i | input | 1 | Serial data line as sensed |
| sda_oe | output | 1 | Drive SDA low when 1 (acknowledge) |
| vblank | input | 1 | Vertical-blanking strobe; a rising edge commits a staged byte |
| regs_o | output | 128 | Working registers, sub-address n at bits 8n+7..8n |

## Verification
A wrong bit counter or protocol state shows up at the acknowledge slot of the same byte: sda_oe is either missing or present when it should not be, and the bench samples this while SCL is high. A wrong sub-address pointer shows up as a misplaced byte on regs_o within a few system clocks of the acknowledge, so a full sweep through the wrap point compares every output byte. A lost or stuck staging flag shows up either as a byte that appears before vblank, or as an acknowledge that should have been refused before the commit.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_SUBA,
        RX_DATA,
        RX_SKIP
    } rx_st_e;

    // Storage mask per sub-address: 0 for reserved, 6 bits for
    // adjustment values, 8 bits for the control bytes.
    function automatic logic [7:0] keep_mask(input int unsigned idx);
        case (idx)
            7, 8, 9, 11, 15:      keep_mask = 8'h00;
            12, 13, 14:           keep_mask = 8'hFF;
            default:              keep_mask = 8'h3F;
        endcase
    endfunction

endpackage

// File: rtl/dcr_line_sync.sv
module dcr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pfail_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_pipe[STAGES-1];
        s_d.sda_prev = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge pfail_n) begin
        if (!pfail_n) s_q <= '1;
        else          s_q <= s_d;
    end

    assign scl_s     = s_q.scl_pipe[STAGES-1];
    assign sda_s     = s_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_prev;
    assign scl_fall  = ~scl_s & s_q.scl_prev;
    assign start_det = scl_s & s_q.scl_prev & s_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_prev & ~s_q.sda_prev & sda_s;

endmodule

// File: rtl/dcr_byte_rx.sv
module dcr_byte_rx
    import dcr_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h88,
    parameter int         NREG     = 16,
    localparam int        SUB_W    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             pfail_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             buf_mode,
    input  logic             pending,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [SUB_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             wr_buf
);

    typedef struct packed {
        rx_st_e           st;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic             ack_ph;
        logic             oe;
        logic [SUB_W-1:0] sub;
        logic             first;
        logic             wr_en;
        logic [SUB_W-1:0] wr_addr;
        logic [7:0]       wr_data;
        logic             wr_buf;
    } rx_t;

    rx_t r_q, r_d;

    // A single acknowledge routine keeps the slot handling the same
    // for every byte kind.
    always_comb begin
        logic take;
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        take      = 1'b0;
        if (start_det) begin
            r_d.st     = RX_ADDR;
            r_d.bitcnt = '0;
            r_d.ack_ph = 1'b0;
            r_d.oe     = 1'b0;
            r_d.first  = 1'b1;
        end else if (stop_det) begin
            r_d.st     = RX_IDLE;
            r_d.ack_ph = 1'b0;
            r_d.oe     = 1'b0;
        end else if (r_q.st == RX_ADDR || r_q.st == RX_SUBA || r_q.st == RX_DATA) begin
            if (r_q.ack_ph) begin
                if (scl_fall) begin
                    r_d.oe     = 1'b0;
                    r_d.ack_ph = 1'b0;
                    r_d.bitcnt = '0;
                end
            end else if (scl_rise && r_q.bitcnt < 4'd8) begin
                r_d.shreg  = {r_q.shreg[6:0], sda_s};
                r_d.bitcnt = r_q.bitcnt + 4'd1;
            end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                case (r_q.st)
                    RX_ADDR: begin
                        take = (r_q.shreg == DEV_ADDR);
                        r_d.st = RX_SUBA;
                    end
                    RX_SUBA: begin
                        take    = (int'(r_q.shreg) < NREG);
                        r_d.sub = r_q.shreg[SUB_W-1:0];
                        r_d.st  = RX_DATA;
                    end
                    default: begin
                        if (!buf_mode) begin
                            take        = 1'b1;
                            r_d.wr_en   = 1'b1;
                            r_d.wr_buf  = 1'b0;
                            r_d.wr_addr = r_q.sub;
                            r_d.wr_data = r_q.shreg;
                            r_d.sub     = r_q.sub + 1'b1;
                        end else if (r_q.first && !pending) begin
                            take        = 1'b1;
                            r_d.wr_en   = 1'b1;
                            r_d.wr_buf  = 1'b1;
                            r_d.wr_addr = r_q.sub;
                            r_d.wr_data = r_q.shreg;
                            r_d.first   = 1'b0;
                        end
                    end
                endcase
                if (take) begin
                    r_d.oe     = 1'b1;
                    r_d.ack_ph = 1'b1;
                end else begin
                    r_d.st = RX_SKIP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge pfail_n) begin
        if (!pfail_n) begin
            r_q    <= '0;
            r_q.st <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe  = r_q.oe;
    assign wr_en   = r_q.wr_en;
    assign wr_addr = r_q.wr_addr;
    assign wr_data = r_q.wr_data;
    assign wr_buf  = r_q.wr_buf;

    // R2: the acknowledge is released on the falling edge that ends the slot
    p_ack_release_r2: assert property (@(posedge clk) disable iff (!pfail_n)
        (r_q.oe && r_q.ack_ph && scl_fall && !start_det && !stop_det) |=> !sda_oe);

    // R10: a refused transfer never drives the line
    p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!pfail_n)
        (r_q.st == RX_SKIP) |-> !sda_oe);

endmodule

// File: rtl/dcr_reg_store.sv
module dcr_reg_store
    import dcr_pkg::*;
#(
    parameter int  NREG     = 16,
    parameter int  DW       = 8,
    parameter int  BUF_IDX  = 12,
    parameter int  BUF_BIT  = 5,
    localparam int SUB_W    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             pfail_n,
    input  logic             vblank,
    input  logic             wr_en,
    input  logic [SUB_W-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_buf,
    output logic             buf_mode,
    output logic             pending,
    output logic [NREG*DW-1:0] regs_o
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] work;
        logic [SUB_W-1:0]        stg_addr;
        logic [DW-1:0]           stg_data;
        logic                    pend;
        logic                    vb_prev;
    } st_t;

    st_t s_q, s_d;
    logic vb_rise;

    assign vb_rise = vblank & ~s_q.vb_prev;

    always_comb begin
        s_d         = s_q;
        s_d.vb_prev = vblank;
        if (s_q.pend && vb_rise) begin
            s_d.work[s_q.stg_addr] = s_q.stg_data & keep_mask(int'(s_q.stg_addr));
            s_d.pend               = 1'b0;
        end
        if (wr_en) begin
            if (wr_buf) begin
                s_d.stg_addr = wr_addr;
                s_d.stg_data = wr_data;
                s_d.pend     = 1'b1;
            end else begin
                s_d.work[wr_addr] = wr_data & keep_mask(int'(wr_addr));
            end
        end
    end

    always_ff @(posedge clk or negedge pfail_n) begin
        if (!pfail_n) begin
            s_q <= '0;
            for (int i = 0; i < NREG; i++) begin
                s_q.work[i] <= DW'(8'h01) & keep_mask(i);
            end
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[g*DW +: DW] = s_q.work[g];
    end

    assign buf_mode = s_q.work[BUF_IDX][BUF_BIT];
    assign pending  = s_q.pend;

    // R7: a waiting byte is committed on the blanking edge
    p_commit_clears_r7: assert property (@(posedge clk) disable iff (!pfail_n)
        (s_q.pend && vb_rise) |=> !pending);

    // R8: the receiver never stages over a waiting byte
    p_no_restage_r8: assert property (@(posedge clk) disable iff (!pfail_n)
        pending |-> !(wr_en && wr_buf));

    // R5: immediate write to a 6-bit register lands next cycle
    p_imm_write_r5: assert property (@(posedge clk) disable iff (!pfail_n)
        (wr_en && !wr_buf && wr_addr == '0) |=>
        (regs_o[DW-1:0] == {2'b00, $past(wr_data[5:0])}));

endmodule

// File: rtl/dcr_bank_top.sv
module dcr_bank_top #(
    parameter logic [7:0] DEV_ADDR = 8'h88,
    parameter int         NREG     = 16,
    parameter int         DW       = 8,
    parameter int         STAGES   = 2
) (
    input  logic               clk,
    input  logic               pfail_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               vblank,
    output logic [NREG*DW-1:0] regs_o
);

    localparam int SUB_W = $clog2(NREG);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             buf_mode, pending;
    logic             wr_en, wr_buf;
    logic [SUB_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    dcr_line_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .pfail_n(pfail_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    dcr_byte_rx #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_rx (
        .clk(clk), .pfail_n(pfail_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .buf_mode(buf_mode), .pending(pending), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_buf(wr_buf)
    );

    dcr_reg_store #(.NREG(NREG), .DW(DW)) u_store (
        .clk(clk), .pfail_n(pfail_n), .vblank(vblank), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_buf(wr_buf),
        .buf_mode(buf_mode), .pending(pending), .regs_o(regs_o)
    );

    logic unused_scl_s;
    assign unused_scl_s = scl_s;

endmodule

// File: tb/dcr_bank_top_tb.sv
module dcr_bank_top_tb;

    localparam int Q = 10;

    logic         clk = 1'b0;
    logic         pfail_n = 1'b0;
    logic         scl_drv = 1'b1;
    logic         sda_drv = 1'b1;
    logic         vblank = 1'b0;
    logic         sda_oe;
    logic [127:0] regs_o;
    logic         sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] expv [16];

    assign sda_line = sda_drv & ~sda_oe;

    always #10 clk = ~clk;

    dcr_bank_top u_dut (
        .clk(clk), .pfail_n(pfail_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .vblank(vblank), .regs_o(regs_o)
    );

    function automatic logic [7:0] msk(input int a);
        case (a)
            7, 8, 9, 11, 15: msk = 8'h00;
            12, 13, 14:      msk = 8'hFF;
            default:         msk = 8'h3F;
        endcase
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 16; a++) check(tag, 32'(regs_o[a*8 +: 8]), 32'(expv[a]));
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; scl_drv = 1'b1; wclk(Q);
        sda_drv = 1'b0; wclk(Q);
        scl_drv = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; wclk(Q);
        scl_drv = 1'b1; wclk(Q);
        sda_drv = 1'b1; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wclk(Q);
            scl_drv = 1'b1; wclk(2*Q);
            scl_drv = 1'b0; wclk(Q);
        end
        sda_drv = 1'b1; wclk(Q);
        scl_drv = 1'b1; wclk(Q);
        acked = ~sda_line;
        wclk(Q);
        scl_drv = 1'b0; wclk(Q);
        check("R2 release after slot", 32'(sda_oe), 32'd0);
    endtask

    task automatic pulse_vb;
        vblank = 1'b1; wclk(5);
        vblank = 1'b0; wclk(5);
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ak;
        for (int a = 0; a < 16; a++) expv[a] = 8'h01 & msk(a);
        wclk(4);
        check_all("R9 reset values");
        check("R9 oe in reset", 32'(sda_oe), 32'd0);
        pfail_n = 1'b1;
        wclk(4);

        // R1 and R10: foreign addresses and silence afterwards
        bus_start; send_byte(8'h8A, ak); check("R1 nack 0x8A", 32'(ak), 32'd0);
        send_byte(8'h00, ak); check("R10 silent after nack", 32'(ak), 32'd0);
        bus_stop;
        bus_start; send_byte(8'h90, ak); check("R1 nack 0x90", 32'(ak), 32'd0);
        bus_start; send_byte(8'h88, ak); check("R10 restart after nack", 32'(ak), 32'd1);
        // R3: out-of-range sub-address
        send_byte(8'h10, ak); check("R3 nack sub 0x10", 32'(ak), 32'd0);
        send_byte(8'h3F, ak); check("R3 data ignored", 32'(ak), 32'd0);
        bus_stop;
        bus_start; send_byte(8'h88, ak); send_byte(8'hF3, ak);
        check("R3 nack sub 0xF3", 32'(ak), 32'd0);
        bus_stop;
        check_all("R3 no change");

        // R5, R6, R4: auto-increment sweep across the wrap
        bus_start; send_byte(8'h88, ak); check("R1 ack 0x88", 32'(ak), 32'd1);
        send_byte(8'h05, ak); check("R5 ack sub", 32'(ak), 32'd1);
        for (int k = 0; k < 17; k++) begin
            int a;
            logic [7:0] d;
            a = (5 + k) % 16;
            d = 8'((k * 53 + 29) & 255);
            if (a == 12) d = d & 8'hDF;
            send_byte(d, ak);
            check("R5 data ack", 32'(ak), 32'd1);
            expv[a] = d & msk(a);
        end
        bus_stop;
        check_all("R5 R6 R4 sweep");

        // R6: source-select fields at 0x0D
        bus_start; send_byte(8'h88, ak); send_byte(8'h0D, ak); send_byte(8'h15, ak);
        bus_stop;
        check("R6 switch1 on bit0", 32'(regs_o[13*8+0]), 32'd1);
        check("R6 switch1 dis bit1", 32'(regs_o[13*8+1]), 32'd0);
        check("R6 switch2 on bit2", 32'(regs_o[13*8+2]), 32'd1);
        check("R6 cutoff off bit4", 32'(regs_o[13*8+4]), 32'd1);
        expv[13] = 8'h15;

        // R4: reserved write
        bus_start; send_byte(8'h88, ak); send_byte(8'h0B, ak); send_byte(8'hFF, ak);
        check("R4 reserved ack", 32'(ak), 32'd1);
        bus_stop;
        check_all("R4 reserved no effect");

        // R7, R8: buffered mode
        bus_start; send_byte(8'h88, ak); send_byte(8'h0C, ak); send_byte(8'h20, ak);
        bus_stop;
        expv[12] = 8'h20;
        check_all("R7 mode set");
        bus_start; send_byte(8'h88, ak); send_byte(8'h00, ak); send_byte(8'hFA, ak);
        check("R7 staged ack", 32'(ak), 32'd1);
        send_byte(8'h11, ak); check("R8 second byte nack", 32'(ak), 32'd0);
        bus_stop;
        check_all("R7 held before vblank");
        bus_start; send_byte(8'h88, ak); send_byte(8'h01, ak);
        check("R8 sub ack while pending", 32'(ak), 32'd1);
        send_byte(8'h22, ak); check("R8 data nack while pending", 32'(ak), 32'd0);
        bus_stop;
        vblank = 1'b1; wclk(2);
        expv[0] = 8'h3A;
        check_all("R7 commit on vblank");
        vblank = 1'b0; wclk(5);
        bus_start; send_byte(8'h88, ak); send_byte(8'h0C, ak); send_byte(8'h01, ak);
        check("R7 second stage ack", 32'(ak), 32'd1);
        bus_stop;
        check_all("R7 mode byte held");
        pulse_vb;
        expv[12] = 8'h01;
        check_all("R7 mode byte committed");
        bus_start; send_byte(8'h88, ak); send_byte(8'h02, ak); send_byte(8'hFF, ak);
        send_byte(8'hC7, ak);
        bus_stop;
        expv[2] = 8'h3F; expv[3] = 8'h07;
        check_all("R5 immediate again");

        // R9: power-fail
        pfail_n = 1'b0; wclk(3);
        for (int a = 0; a < 16; a++) expv[a] = 8'h01 & msk(a);
        check_all("R9 power fail");
        pfail_n = 1'b1; wclk(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule